// File: doc/BRIEF.md
# Dual-Channel Output Compare Timer

This block holds a 16-bit up-counter and two output compare channels. A CPU programs it over a byte-wide register bus. Each channel holds a compare value that is loaded one byte at a time. When the counter reaches that value, the channel raises a match flag and, if its output is enabled, drives its compare pin to a programmed level.

The counter advances on a timer tick. The tick is the system clock divided by 2, 4 or 8, or the rising edge of an external clock input, which is synchronised inside the block. Software can also force a channel's pin to its level bit without raising a flag. A shared enable gates the interrupt. Each flag is cleared by a two-step access: read the status register, then touch the channel's low compare byte.

The register bus is a plain single-cycle strobe interface, not a stream. A write takes effect at the clock edge that samples `bus_wr`. Read data is combinational from `bus_addr`. Reads have side effects only on the status register and the low compare bytes. The bus never stalls, so there is no back-pressure.

Top module: `dual_ocmp_timer`

## Requirements
- R1: While and after reset, the counter is 0, both compare values read 0xFF/0xFF, the control and clock-select registers read 0, the status register reads 0, both pins and both pin enables are low, and `irq_o` is low.
- R2: The counter increments by one per timer tick. The clock-select register is at address 1, bits [1:0]: 00 divides by 4, 01 divides by 2, 10 divides by 8, and 11 counts rising edges of `ext_clk`.
- R3: Compare bytes sit at address 4 (A high), 5 (A low), 6 (B high) and 7 (B low). Writing a high byte stops that channel from matching until its low byte is written.
- R4: With divide-by-2, a channel's flag and pin update while the counter equals the compare value.
- R5: With divide-by-4, divide-by-8 or the external clock, the flag and pin update while the counter equals the compare value plus one.
- R6: The control register is at address 0. Bits [1:0] enable pins A/B, bits [3:2] set level A/B, and bit 4 enables the interrupt. `ocmp_oe` follows the enable bits. A match on an enabled channel copies its level to `ocmp_o`. On a disabled channel the pin keeps its value, but the flag is still set.
- R7: A control write with force bit 5 (A) or bit 6 (B) set, and the same channel's enable bit set in that write, copies the written level to the pin. It sets no flag and raises no interrupt. Force bits read back as 0.
- R8: While `pulse_mode` is high, force bits have no effect on the pins.
- R9: Status is at address 2, with bit 0 the A flag and bit 1 the B flag. A flag clears only when the status register is read with that flag set and the channel's low compare byte is then read or written. A low-byte access with no prior status read leaves the flag set.
- R10: `irq_o` is high exactly while the interrupt enable is set and at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| ext_clk | input | 1 | External timer clock, asynchronous |
| pulse_mode | input | 1 | High when a pulse/PWM mode owns the pins; blocks force |
| cnt_o | output | 16 | Current counter value |
| ocmp_o | output | 2 | Compare pin levels, bit 0 = A |
| ocmp_oe | output | 2 | Compare pin drive enables |
| irq_o | output | 1 | Compare interrupt request |

## Verification
The assertions assume that at most one of `bus_rd` and `bus_wr` is high in any cycle, and that each strobe lasts exactly one cycle per access. They also assume `pulse_mode` changes only between bus accesses. The interrupt-hold property relies on flags and the interrupt enable changing only through the bus. The bench drives every access through one read task and one write task, and each task raises a single strobe for one cycle between falling edges. It changes `pulse_mode` only while the bus is idle. The external clock is kept at a period of twenty system cycles, so the synchroniser sees every edge.

// File: rtl/ocmp_pkg.sv
package ocmp_pkg;
  localparam int NCH = 2;

  typedef enum logic [1:0] {
    CK_DIV4 = 2'b00,
    CK_DIV2 = 2'b01,
    CK_DIV8 = 2'b10,
    CK_EXT  = 2'b11
  } ck_sel_e;

  // register addresses
  localparam int A_CTRL = 0;
  localparam int A_CKSEL = 1;
  localparam int A_STAT = 2;
  localparam int A_CMP0 = 4;  // channel c: high at A_CMP0+2c, low at +1

  // control register bit positions
  localparam int B_EN0 = 0;
  localparam int B_LVL0 = 2;
  localparam int B_IRQEN = 4;
  localparam int B_FRC0 = 5;
endpackage

// File: rtl/ocmp_prescaler.sv
module ocmp_prescaler
  import ocmp_pkg::*;
#(
  parameter int DIV_W = 3,
  parameter int SYNC_N = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  ck_sel_e sel,
  input  logic    ext_clk,
  output logic    tick
);
  localparam logic [DIV_W-1:0] LIM2 = DIV_W'(1);
  localparam logic [DIV_W-1:0] LIM4 = DIV_W'(3);
  localparam logic [DIV_W-1:0] LIM8 = DIV_W'(7);

  logic [SYNC_N:0]    ext_sr;
  logic [DIV_W-1:0]   div_q;
  logic [DIV_W-1:0]   lim;
  logic               div_hit;
  logic               ext_rise;

  always_comb begin
    case (sel)
      CK_DIV2: lim = LIM2;
      CK_DIV8: lim = LIM8;
      default: lim = LIM4;
    endcase
  end

  assign div_hit  = (div_q >= lim);
  assign ext_rise = ext_sr[SYNC_N-1] & ~ext_sr[SYNC_N];
  assign tick     = (sel == CK_EXT) ? ext_rise : div_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q  <= '0;
      ext_sr <= '0;
    end else begin
      div_q  <= div_hit ? '0 : div_q + DIV_W'(1);
      ext_sr <= {ext_sr[SYNC_N-1:0], ext_clk};
    end
  end

  // R2: at divide-by-2 no two ticks are adjacent
  a_r2_div2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == CK_DIV2 && tick) |=> (sel != CK_DIV2 || !tick));
endmodule

// File: rtl/ocmp_channel.sv
module ocmp_channel #(
  parameter int CNT_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              cnt_new,
  input  logic              late,
  input  logic              wr_hi,
  input  logic              wr_lo,
  input  logic              lo_acc,
  input  logic [DATA_W-1:0] wdata,
  input  logic              stat_rd,
  input  logic              en,
  input  logic              lvl,
  input  logic              frc_req,
  input  logic              frc_lvl,
  output logic [CNT_W-1:0]  cmp_q,
  output logic              flag_q,
  output logic              pin_q
);
  logic             armed_q;
  logic             seen_q;
  logic [CNT_W-1:0] target;
  logic             match;

  assign target = late ? cmp_q + CNT_W'(1) : cmp_q;
  assign match  = armed_q && cnt_new && (cnt == target);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '1;
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
      flag_q  <= 1'b0;
      pin_q   <= 1'b0;
    end else begin
      if (wr_hi) begin
        cmp_q[CNT_W-1:DATA_W] <= wdata;
        armed_q <= 1'b0;
      end else if (wr_lo) begin
        cmp_q[DATA_W-1:0] <= wdata;
        armed_q <= 1'b1;
      end
      if (stat_rd && flag_q)  seen_q <= 1'b1;
      else if (lo_acc)        seen_q <= 1'b0;
      if (match)                    flag_q <= 1'b1;
      else if (lo_acc && seen_q)    flag_q <= 1'b0;
      if (frc_req)            pin_q <= frc_lvl;
      else if (match && en)   pin_q <= lvl;
    end
  end

  // R3: a disarmed channel never raises its flag
  a_r3_disarmed_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed_q && !flag_q) |=> !flag_q);
  // R7: forcing the pin never raises the flag
  a_r7_force_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (frc_req && !match && !flag_q) |=> !flag_q);
  // R6: a disabled channel leaves its pin latch alone
  a_r6_disabled_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !frc_req) |=> $stable(pin_q));
endmodule

// File: rtl/dual_ocmp_timer.sv
module dual_ocmp_timer
  import ocmp_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_clk,
  input  logic              pulse_mode,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [NCH-1:0]    ocmp_o,
  output logic [NCH-1:0]    ocmp_oe,
  output logic              irq_o
);
  logic [NCH-1:0]   en_q, lvl_q, flags;
  logic             irq_en_q;
  ck_sel_e          cksel_q;
  logic             tick, cnt_new_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cmp_w [NCH];
  logic             ctrl_wr, stat_rd;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(A_CTRL));
  assign stat_rd = bus_rd && (bus_addr == ADDR_W'(A_STAT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      lvl_q    <= '0;
      irq_en_q <= 1'b0;
      cksel_q  <= CK_DIV4;
    end else if (bus_wr) begin
      if (bus_addr == ADDR_W'(A_CTRL)) begin
        en_q     <= bus_wdata[B_EN0 +: NCH];
        lvl_q    <= bus_wdata[B_LVL0 +: NCH];
        irq_en_q <= bus_wdata[B_IRQEN];
      end
      if (bus_addr == ADDR_W'(A_CKSEL))
        cksel_q <= ck_sel_e'(bus_wdata[1:0]);
    end
  end

  ocmp_prescaler u_presc (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (cksel_q),
    .ext_clk (ext_clk),
    .tick    (tick)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      cnt_new_q <= 1'b0;
    end else begin
      if (tick) cnt_q <= cnt_q + CNT_W'(1);
      cnt_new_q <= tick;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic hi_sel, lo_sel;
    assign hi_sel = (bus_addr == ADDR_W'(A_CMP0 + 2*c));
    assign lo_sel = (bus_addr == ADDR_W'(A_CMP0 + 2*c + 1));

    ocmp_channel #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt     (cnt_q),
      .cnt_new (cnt_new_q),
      .late    (cksel_q != CK_DIV2),
      .wr_hi   (bus_wr && hi_sel),
      .wr_lo   (bus_wr && lo_sel),
      .lo_acc  ((bus_wr || bus_rd) && lo_sel),
      .wdata   (bus_wdata),
      .stat_rd (stat_rd),
      .en      (en_q[c]),
      .lvl     (lvl_q[c]),
      .frc_req (ctrl_wr && bus_wdata[B_FRC0+c] && bus_wdata[B_EN0+c] && !pulse_mode),
      .frc_lvl (bus_wdata[B_LVL0+c]),
      .cmp_q   (cmp_w[c]),
      .flag_q  (flags[c]),
      .pin_q   (ocmp_o[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(A_CTRL)) begin
      bus_rdata[B_EN0 +: NCH]  = en_q;
      bus_rdata[B_LVL0 +: NCH] = lvl_q;
      bus_rdata[B_IRQEN]       = irq_en_q;
    end
    if (bus_addr == ADDR_W'(A_CKSEL)) bus_rdata[1:0] = cksel_q;
    if (bus_addr == ADDR_W'(A_STAT))  bus_rdata[NCH-1:0] = flags;
    for (int c = 0; c < NCH; c++) begin
      if (bus_addr == ADDR_W'(A_CMP0 + 2*c))     bus_rdata = cmp_w[c][CNT_W-1:DATA_W];
      if (bus_addr == ADDR_W'(A_CMP0 + 2*c + 1)) bus_rdata = cmp_w[c][DATA_W-1:0];
    end
  end

  assign cnt_o   = cnt_q;
  assign ocmp_oe = en_q;
  assign irq_o   = irq_en_q && (|flags);

  // R10: with the bus idle, a pending interrupt cannot drop
  a_r10_irq_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !bus_rd && !bus_wr) |=> irq_o);
endmodule

// File: tb/dual_ocmp_timer_test.sv
`timescale 1ns/100ps
module dual_ocmp_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        ext_clk = 1'b0;
  logic        pulse_mode = 1'b0;
  logic [15:0] cnt_o;
  logic [1:0]  ocmp_o, ocmp_oe;
  logic        irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dual_ocmp_timer uut (.*);

  always #2.5 clk = ~clk;
  always begin
    repeat (10) @(negedge clk);
    ext_clk = ~ext_clk;
  end

  // vector: {channel, clock select, compare value, counter value when flag appears}
  localparam logic [34:0] VEC [5] = '{
    {1'b0, 2'b01, 16'h0010, 16'h0010},
    {1'b0, 2'b00, 16'h0008, 16'h0009},
    {1'b1, 2'b10, 16'h0006, 16'h0007},
    {1'b1, 2'b11, 16'h0004, 16'h0005},
    {1'b1, 2'b01, 16'h0020, 16'h0020}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0; pulse_mode = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cnt(input logic [15:0] v);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      if (cnt_o == v) return;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0]  d;
    logic [15:0] c0;

    // R1 reset state
    repeat (2) @(negedge clk);
    chk("R1 cnt", cnt_o, 0);
    chk("R1 pins", {ocmp_oe, ocmp_o}, 0);
    chk("R1 irq", irq_o, 0);
    rst_n = 1'b1;
    rd(3'd4, d); chk("R1 cmpA hi", d, 8'hFF);
    rd(3'd7, d); chk("R1 cmpB lo", d, 8'hFF);
    rd(3'd0, d); chk("R1 ctrl", d, 0);
    rd(3'd1, d); chk("R1 cksel", d, 0);
    rd(3'd2, d); chk("R1 status", d, 0);

    // R2 prescale rates
    wr(3'd1, 8'h01);
    @(negedge clk); c0 = cnt_o; repeat (40) @(negedge clk);
    chk("R2 div2 rate", cnt_o - c0, 20);
    wr(3'd1, 8'h02);
    @(negedge clk); c0 = cnt_o; repeat (80) @(negedge clk);
    chk("R2 div8 rate", cnt_o - c0, 10);
    wr(3'd1, 8'h03);
    @(negedge clk); c0 = cnt_o; repeat (200) @(negedge clk);
    chk("R2 ext rate", cnt_o - c0, 10);

    // R4 R5 R6 match timing table
    foreach (VEC[k]) begin
      automatic int          ch = int'(VEC[k][34]);
      automatic logic [15:0] cv = VEC[k][31:16];
      automatic logic [15:0] ex = VEC[k][15:0];
      automatic bit          seen_irq = 0;
      do_reset();
      wr(3'd1, {6'b0, VEC[k][33:32]});
      wr(3'(4 + 2*ch), cv[15:8]);
      wr(3'(5 + 2*ch), cv[7:0]);
      wr(3'd0, 8'(8'h10 | (8'h01 << ch) | (8'h04 << ch)));
      for (int i = 0; i < 20000 && !seen_irq; i++) begin
        @(negedge clk);
        if (irq_o) seen_irq = 1;
      end
      chk(VEC[k][33:32] == 2'b01 ? "R4 match count" : "R5 match count", cnt_o, ex);
      chk("R6 pin level", ocmp_o[ch], 1);
      chk("R6 pin enable", ocmp_oe[ch], 1);
    end

    // R3 high-byte write disarms until low byte
    do_reset();
    wr(3'd1, 8'h01);
    wr(3'd4, 8'h00); wr(3'd5, 8'h40);
    wr(3'd0, 8'h15);
    wr(3'd4, 8'h00);
    wait_cnt(16'h0048);
    chk("R3 disarmed no flag", irq_o, 0);
    chk("R3 disarmed pin", ocmp_o[0], 0);
    wr(3'd5, 8'h60);
    wait_cnt(16'h0061);
    @(negedge clk);
    chk("R3 rearmed flag", irq_o, 1);

    // R9 clear sequence, R10 interrupt gating
    rd(3'd5, d);
    chk("R9 lo access alone keeps flag", irq_o, 1);
    wr(3'd0, 8'h05);
    chk("R10 irq off when disabled", irq_o, 0);
    wr(3'd0, 8'h15);
    chk("R10 irq back on", irq_o, 1);
    rd(3'd2, d);
    chk("R9 status shows flag A", d, 8'h01);
    rd(3'd5, d);
    chk("R9 flag cleared irq", irq_o, 0);
    rd(3'd2, d);
    chk("R9 status clear", d, 0);

    // R6 disabled channel: flag set, pin untouched
    do_reset();
    wr(3'd1, 8'h01);
    wr(3'd6, 8'h00); wr(3'd7, 8'h30);
    wr(3'd0, 8'h18);
    wait_cnt(16'h0031);
    rd(3'd2, d);
    chk("R6 disabled flag set", d, 8'h02);
    chk("R6 disabled oe", ocmp_oe[1], 0);
    chk("R6 disabled pin held", ocmp_o[1], 0);

    // R7 force, R8 blocked in pulse mode
    do_reset();
    wr(3'd0, 8'h35);
    chk("R7 forced pin", ocmp_o[0], 1);
    chk("R7 no irq", irq_o, 0);
    rd(3'd2, d);
    chk("R7 no flag", d, 0);
    rd(3'd0, d);
    chk("R7 force reads zero", d, 8'h15);
    @(negedge clk); pulse_mode = 1'b1;
    wr(3'd0, 8'h31);
    chk("R8 force blocked", ocmp_o[0], 1);
    @(negedge clk); pulse_mode = 1'b0;
    wr(3'd0, 8'h31);
    chk("R8 force active again", ocmp_o[0], 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule